// File: doc/BRIEF.md
# Inter-processor doorbell message router

This block carries doorbell messages between the cores of a small cluster. A core that wants to wake or notify its peers issues a send command with a 32-bit message word. The router decodes the message type into one of three doorbell classes, works out which cores are addressed, and sets the matching sticky pending bit on each addressed core. A core can also issue a clear command with a message word. The decoded pending bit is then removed from that core alone. Each core reports its pending vector and a request line that is high while any of its doorbells is pending. Taking the interrupt after that point belongs to the core.

The decode rules are chosen at elaboration by the `SERVER_MODE` parameter. In embedded mode there are two usable classes, normal and critical, and a broadcast flag. In server mode there is one usable type, which raises the hypervisor doorbell. Server mode has no broadcast, and every other type code does nothing. Each core's identity is a tag presented on `core_id_i`, and a directed send reaches every core whose tag matches.

Message word: type code in bits [31:27], broadcast flag in bit 26, target tag in bits [13:0]. Bits [25:14] are reserved and ignored. Pending vector per core: bit 0 is the normal doorbell, bit 1 is the critical doorbell and bit 2 is the hypervisor doorbell.

Top module: `dbell_router`

## Requirements
- R1: While reset is low, every pending bit and every request line is 0.
- R2: In embedded mode, a send with type code 0 sets pending bit 0 at the next clock edge on every core whose tag equals message bits [13:0].
- R3: In embedded mode, a send with type code 1 sets pending bit 1 on the addressed cores at the next clock edge.
- R4: In embedded mode, type codes 2 to 31 decode to no doorbell. A send or a clear carrying one of them changes no pending bit, and pending bit 2 is never set.
- R5: In embedded mode, when bit 26 is 1, a send of a valid type sets the bit on all cores, whatever their tags.
- R6: In server mode, a send with type code 5 sets pending bit 2 only on cores whose tag matches. Bit 26 has no effect.
- R7: In server mode, every type code other than 5 makes both send and clear a no-op, and pending bits 0 and 1 are never set.
- R8: A clear command removes the decoded pending bit only on the core named by `clr_core_i`. The bits of other cores and the other bits of that core are kept.
- R9: When a send and a clear hit the same bit of the same core in one cycle, the bit is 1 afterwards.
- R10: Each core's request line is 1 exactly when at least one of its pending bits is 1.
- R11: A pending bit, once set, stays set until a clear removes it. A repeated send leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_id_i | input | NUM_CORES*TAG_W | Tag of each core, core c at [c*TAG_W +: TAG_W] |
| snd_valid_i | input | 1 | Send command present this cycle |
| snd_msg_i | input | MSG_W | Message word of the send |
| clr_valid_i | input | 1 | Clear command present this cycle |
| clr_core_i | input | CIDX_W | Index of the core issuing the clear |
| clr_msg_i | input | MSG_W | Message word of the clear |
| pend_o | output | NUM_CORES*3 | Pending doorbell bits, core c at [c*3 +: 3] |
| irq_o | output | NUM_CORES | Per-core request, high while any bit is pending |

## Verification
The properties assume that the core tags stay fixed after reset. They also assume that `clr_core_i` names an existing core whenever a clear is valid, because a clear aimed at an index beyond the array is silently dropped. The stimulus holds the tag vector constant over the whole run and draws clear indices only from the implemented cores. It draws target tags mostly from the configured tags, including a tag shared by two cores, so that directed matches, including multiple matches, occur often. It also drives the same commands into an embedded-mode instance and a server-mode instance, so that both decoders see identical words, reserved and guest type codes included.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

   localparam int NUM_CLASS = 3;
   localparam int CLS_NORM  = 0;
   localparam int CLS_CRIT  = 1;
   localparam int CLS_HYP   = 2;

   localparam int TYPE_W = 5;

   localparam logic [TYPE_W-1:0] TY_DB      = 5'd0;
   localparam logic [TYPE_W-1:0] TY_DB_CRIT = 5'd1;
   localparam logic [TYPE_W-1:0] TY_GDB     = 5'd2;
   localparam logic [TYPE_W-1:0] TY_GDB_CRIT= 5'd3;
   localparam logic [TYPE_W-1:0] TY_GDB_MC  = 5'd4;
   localparam logic [TYPE_W-1:0] TY_SRV_HYP = 5'd5;

   typedef logic [NUM_CLASS-1:0] cls_vec_t;

   typedef struct packed {
      logic     valid;
      cls_vec_t cls;
      logic     bcast;
   } dbell_dec_t;

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
   import dbell_pkg::*;
#(
   parameter bit SERVER_MODE = 1'b0
) (
   input  logic [TYPE_W-1:0] type_i,
   input  logic              bcast_i,
   output dbell_dec_t        dec_o
);

   generate
      if (SERVER_MODE) begin : g_server
         logic unused_bcast;
         assign unused_bcast = bcast_i;
         always_comb begin
            dec_o = '0;
            if (type_i == TY_SRV_HYP) begin
               dec_o.valid       = 1'b1;
               dec_o.cls[CLS_HYP] = 1'b1;
            end
         end
      end else begin : g_embedded
         always_comb begin
            dec_o = '0;
            unique case (type_i)
               TY_DB: begin
                  dec_o.valid        = 1'b1;
                  dec_o.cls[CLS_NORM] = 1'b1;
                  dec_o.bcast        = bcast_i;
               end
               TY_DB_CRIT: begin
                  dec_o.valid        = 1'b1;
                  dec_o.cls[CLS_CRIT] = 1'b1;
                  dec_o.bcast        = bcast_i;
               end
               TY_GDB, TY_GDB_CRIT, TY_GDB_MC: dec_o = '0;
               default: dec_o = '0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/dbell_match.sv
module dbell_match #(
   parameter int TAG_W = 14
) (
   input  logic [TAG_W-1:0] tag_i,
   input  logic [TAG_W-1:0] id_i,
   input  logic             bcast_i,
   output logic             hit_o
);

   logic tag_eq;

   assign tag_eq = (tag_i == id_i);
   assign hit_o  = bcast_i | tag_eq;

endmodule

// File: rtl/dbell_pend_cell.sv
module dbell_pend_cell
   import dbell_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  cls_vec_t set_i,
   input  cls_vec_t clr_i,
   output cls_vec_t pend_o,
   output logic     irq_o
);

   cls_vec_t pend_q;
   cls_vec_t pend_d;

   // clear first, then set: a send wins over a clear on the same bit
   always_comb begin
      pend_d = (pend_q & ~clr_i) | set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   assign pend_o = pend_q;
   assign irq_o  = |pend_q;

endmodule

// File: rtl/dbell_router.sv
module dbell_router
   import dbell_pkg::*;
#(
   parameter int NUM_CORES   = 4,
   parameter int MSG_W       = 32,
   parameter int TAG_W       = 14,
   parameter int BCAST_BIT   = 26,
   parameter bit SERVER_MODE = 1'b0,
   localparam int CIDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int TYPE_LSB   = MSG_W - TYPE_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_CORES*TAG_W-1:0]     core_id_i,
   input  logic                           snd_valid_i,
   input  logic [MSG_W-1:0]               snd_msg_i,
   input  logic                           clr_valid_i,
   input  logic [CIDX_W-1:0]              clr_core_i,
   input  logic [MSG_W-1:0]               clr_msg_i,
   output logic [NUM_CORES*NUM_CLASS-1:0] pend_o,
   output logic [NUM_CORES-1:0]           irq_o
);

   // elaboration-time parameter checks
   generate
      if (NUM_CORES < 1) begin : g_bad_cores
         $error("dbell_router: NUM_CORES must be at least 1");
      end
      if (BCAST_BIT >= TYPE_LSB) begin : g_bad_bcast
         $error("dbell_router: broadcast bit overlaps the type field");
      end
      if (TAG_W > BCAST_BIT) begin : g_bad_tag
         $error("dbell_router: tag field overlaps the broadcast bit");
      end
   endgenerate

   // field extraction
   logic [TYPE_W-1:0] snd_type, clr_type;
   logic [TAG_W-1:0]  snd_tag;
   logic              snd_bcast, clr_bcast;

   assign snd_type  = snd_msg_i[MSG_W-1:TYPE_LSB];
   assign clr_type  = clr_msg_i[MSG_W-1:TYPE_LSB];
   assign snd_tag   = snd_msg_i[TAG_W-1:0];
   assign snd_bcast = snd_msg_i[BCAST_BIT];
   assign clr_bcast = clr_msg_i[BCAST_BIT];

   // reserved bits and the clear's target fields carry no meaning
   logic unused_fields;
   generate
      if (BCAST_BIT > TAG_W) begin : g_rsvd
         assign unused_fields = ^{snd_msg_i[BCAST_BIT-1:TAG_W],
                                  clr_msg_i[BCAST_BIT-1:0]};
      end else begin : g_no_rsvd
         assign unused_fields = ^clr_msg_i[BCAST_BIT-1:0];
      end
   endgenerate

   // decoders, one per command
   dbell_dec_t snd_dec, clr_dec;

   dbell_decode #(.SERVER_MODE(SERVER_MODE)) u_snd_dec (
      .type_i  (snd_type),
      .bcast_i (snd_bcast),
      .dec_o   (snd_dec)
   );

   dbell_decode #(.SERVER_MODE(SERVER_MODE)) u_clr_dec (
      .type_i  (clr_type),
      .bcast_i (clr_bcast),
      .dec_o   (clr_dec)
   );

   logic unused_clr_dec;
   assign unused_clr_dec = clr_dec.bcast;

   logic snd_go, clr_go;
   assign snd_go = snd_valid_i & snd_dec.valid;
   assign clr_go = clr_valid_i & clr_dec.valid;

   // per-core targeting and pending state
   genvar c;
   generate
      for (c = 0; c < NUM_CORES; c++) begin : g_core
         logic     hit;
         logic     is_issuer;
         cls_vec_t set_m, clr_m, pend_c;
         logic     irq_c;

         dbell_match #(.TAG_W(TAG_W)) u_match (
            .tag_i   (snd_tag),
            .id_i    (core_id_i[c*TAG_W +: TAG_W]),
            .bcast_i (snd_dec.bcast),
            .hit_o   (hit)
         );

         assign is_issuer = (clr_core_i == CIDX_W'(c));
         assign set_m = (snd_go & hit)       ? snd_dec.cls : '0;
         assign clr_m = (clr_go & is_issuer) ? clr_dec.cls : '0;

         dbell_pend_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_m),
            .clr_i  (clr_m),
            .pend_o (pend_c),
            .irq_o  (irq_c)
         );

         assign pend_o[c*NUM_CLASS +: NUM_CLASS] = pend_c;
         assign irq_o[c] = irq_c;
      end
   endgenerate

endmodule

// File: rtl/dbell_router_chk.sv
module dbell_router_chk
   import dbell_pkg::*;
#(
   parameter int NUM_CORES   = 4,
   parameter int MSG_W       = 32,
   parameter int TAG_W       = 14,
   parameter int BCAST_BIT   = 26,
   parameter bit SERVER_MODE = 1'b0,
   parameter int CIDX_W      = 2
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [NUM_CORES*TAG_W-1:0]     core_id_i,
   input logic                           snd_valid_i,
   input logic [MSG_W-1:0]               snd_msg_i,
   input logic                           clr_valid_i,
   input logic [CIDX_W-1:0]              clr_core_i,
   input logic [MSG_W-1:0]               clr_msg_i,
   input logic [NUM_CORES*NUM_CLASS-1:0] pend_o,
   input logic [NUM_CORES-1:0]           irq_o
);

   localparam int TYPE_LSB = MSG_W - TYPE_W;

   logic [TYPE_W-1:0] s_type;
   assign s_type = snd_msg_i[MSG_W-1:TYPE_LSB];

   logic unused_chk;
   assign unused_chk = ^clr_msg_i;

   always @(negedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (pend_o == '0 && irq_o == '0);
      end
   end

   genvar c, k;
   generate
      for (c = 0; c < NUM_CORES; c++) begin : g_c
         for (k = 0; k < NUM_CLASS; k++) begin : g_k
            assert_rise_needs_send_R11: assert property (@(posedge clk) disable iff (!rst_n)
               $rose(pend_o[c*NUM_CLASS+k]) |-> $past(snd_valid_i));
            assert_fall_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
               $fell(pend_o[c*NUM_CLASS+k]) |-> $past(clr_valid_i && clr_core_i == CIDX_W'(c)));
         end

         assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[c]) |-> $past(snd_valid_i));

         if (SERVER_MODE) begin : g_srv
            assert_srv_confined_R7: assert property (@(posedge clk) disable iff (!rst_n)
               pend_o[c*NUM_CLASS +: 2] == 2'b00);
            assert_srv_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
               (snd_valid_i && s_type == TY_SRV_HYP &&
                snd_msg_i[TAG_W-1:0] == core_id_i[c*TAG_W +: TAG_W])
               |=> pend_o[c*NUM_CLASS+CLS_HYP]);
         end else begin : g_emb
            assert_no_hyp_R4: assert property (@(posedge clk) disable iff (!rst_n)
               pend_o[c*NUM_CLASS+CLS_HYP] == 1'b0);
            assert_bcast_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
               (snd_valid_i && snd_msg_i[BCAST_BIT] && s_type == TY_DB)
               |=> pend_o[c*NUM_CLASS+CLS_NORM]);
            assert_crit_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
               (snd_valid_i && s_type == TY_DB_CRIT &&
                snd_msg_i[TAG_W-1:0] == core_id_i[c*TAG_W +: TAG_W])
               |=> pend_o[c*NUM_CLASS+CLS_CRIT]);
         end
      end
   endgenerate

endmodule

bind dbell_router dbell_router_chk #(
   .NUM_CORES   (NUM_CORES),
   .MSG_W       (MSG_W),
   .TAG_W       (TAG_W),
   .BCAST_BIT   (BCAST_BIT),
   .SERVER_MODE (SERVER_MODE),
   .CIDX_W      (CIDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .core_id_i   (core_id_i),
   .snd_valid_i (snd_valid_i),
   .snd_msg_i   (snd_msg_i),
   .clr_valid_i (clr_valid_i),
   .clr_core_i  (clr_core_i),
   .clr_msg_i   (clr_msg_i),
   .pend_o      (pend_o),
   .irq_o       (irq_o)
);

// File: tb/dbell_router_bench.sv
module dbell_router_bench;

   localparam int  CLK_PERIOD = 10;
   localparam int  NC  = 4;
   localparam int  TW  = 14;
   localparam int  MW  = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NC*TW-1:0] ids;
   logic            snd_v = 1'b0;
   logic [MW-1:0]   snd_m = '0;
   logic            clr_v = 1'b0;
   logic [1:0]      clr_c = '0;
   logic [MW-1:0]   clr_m = '0;
   logic [NC*3-1:0] pend_e, pend_s;
   logic [NC-1:0]   irq_e, irq_s;

   logic [2:0] exp_e [NC];
   logic [2:0] exp_s [NC];

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // core 0 and core 2 share a tag
   assign ids = {14'h3FFF, 14'h0010, 14'h0021, 14'h0010};

   dbell_router #(.NUM_CORES(NC), .SERVER_MODE(1'b0)) u_dbell_router (
      .clk(clk), .rst_n(rst_n), .core_id_i(ids),
      .snd_valid_i(snd_v), .snd_msg_i(snd_m),
      .clr_valid_i(clr_v), .clr_core_i(clr_c), .clr_msg_i(clr_m),
      .pend_o(pend_e), .irq_o(irq_e));

   dbell_router #(.NUM_CORES(NC), .SERVER_MODE(1'b1)) u_dbell_router_srv (
      .clk(clk), .rst_n(rst_n), .core_id_i(ids),
      .snd_valid_i(snd_v), .snd_msg_i(snd_m),
      .clr_valid_i(clr_v), .clr_core_i(clr_c), .clr_msg_i(clr_m),
      .pend_o(pend_s), .irq_o(irq_s));

   function automatic logic [MW-1:0] mk(input int ty, input bit bc, input int tag);
      logic [MW-1:0] m;
      m = '0;
      m[31:27] = ty[4:0];
      m[26]    = bc;
      m[13:0]  = tag[13:0];
      return m;
   endfunction

   function automatic logic [2:0] cls_e(input logic [MW-1:0] m);
      if (m[31:27] == 5'd0) return 3'b001;
      if (m[31:27] == 5'd1) return 3'b010;
      return 3'b000;
   endfunction

   function automatic logic [2:0] cls_s(input logic [MW-1:0] m);
      return (m[31:27] == 5'd5) ? 3'b100 : 3'b000;
   endfunction

   function automatic bit hit(input logic [MW-1:0] m, input int c, input bit srv);
      if (!srv && m[26]) return 1'b1;
      return m[13:0] == ids[c*TW +: TW];
   endfunction

   task automatic model_step();
      for (int c = 0; c < NC; c++) begin
         logic [2:0] se, ce, ss, cs;
         se = (snd_v && hit(snd_m, c, 1'b0)) ? cls_e(snd_m) : 3'b000;
         ss = (snd_v && hit(snd_m, c, 1'b1)) ? cls_s(snd_m) : 3'b000;
         ce = (clr_v && clr_c == 2'(c)) ? cls_e(clr_m) : 3'b000;
         cs = (clr_v && clr_c == 2'(c)) ? cls_s(clr_m) : 3'b000;
         exp_e[c] = (exp_e[c] & ~ce) | se;
         exp_s[c] = (exp_s[c] & ~cs) | ss;
      end
   endtask

   task automatic check_all(input string req);
      for (int c = 0; c < NC; c++) begin
         n_cmp++;
         if (pend_e[c*3 +: 3] !== exp_e[c] || irq_e[c] !== (|exp_e[c])) begin
            n_bad++;
            $display("FAIL %s embedded core %0d: pend=%b irq=%b expected pend=%b irq=%b",
                     req, c, pend_e[c*3 +: 3], irq_e[c], exp_e[c], |exp_e[c]);
         end
         n_cmp++;
         if (pend_s[c*3 +: 3] !== exp_s[c] || irq_s[c] !== (|exp_s[c])) begin
            n_bad++;
            $display("FAIL %s server core %0d: pend=%b irq=%b expected pend=%b irq=%b",
                     req, c, pend_s[c*3 +: 3], irq_s[c], exp_s[c], |exp_s[c]);
         end
      end
   endtask

   // one command cycle: drive, clock, update model, sample 1 time unit later
   task automatic cyc(input bit sv, input logic [MW-1:0] sm,
                      input bit cv, input int cc, input logic [MW-1:0] cm,
                      input string req);
      snd_v = sv; snd_m = sm; clr_v = cv; clr_c = cc[1:0]; clr_m = cm;
      @(posedge clk);
      model_step();
      #1;
      snd_v = 1'b0; clr_v = 1'b0;
      check_all(req);
   endtask

   initial begin
      for (int c = 0; c < NC; c++) begin exp_e[c] = '0; exp_s[c] = '0; end
      #(CLK_PERIOD*2 + 2);
      check_all("R1");
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      cyc(1, mk(0, 0, 'h10), 0, 0, '0, "R2");       // cores 0 and 2
      cyc(1, mk(1, 0, 'h3FFF), 0, 0, '0, "R3");     // core 3 critical
      cyc(1, mk(2, 1, 'h21), 0, 0, '0, "R4");
      cyc(1, mk(3, 0, 'h21), 0, 0, '0, "R4");
      cyc(1, mk(4, 1, 'h10), 0, 0, '0, "R4");
      cyc(1, mk(9, 0, 'h21), 1, 0, mk(7, 0, 0), "R4");
      cyc(1, mk(1, 1, 'h0123), 0, 0, '0, "R5");     // broadcast critical
      cyc(1, mk(5, 1, 'h21), 0, 0, '0, "R6");       // server core 1 only
      cyc(0, '0, 1, 1, mk(6, 0, 0), "R7");
      cyc(1, mk(7, 1, 'h21), 0, 0, '0, "R7");
      cyc(0, '0, 1, 0, mk(0, 0, 'h3FFF), "R8");     // clear on core 0 only
      cyc(0, '0, 1, 2, mk(1, 1, 0), "R8");
      cyc(1, mk(0, 0, 'h10), 0, 0, '0, "R11");
      cyc(1, mk(0, 0, 'h10), 0, 0, '0, "R11");
      cyc(1, mk(0, 0, 'h10), 1, 2, mk(0, 0, 0), "R9");
      cyc(1, mk(5, 0, 'h21), 1, 1, mk(5, 0, 0), "R9");
      cyc(0, '0, 1, 1, mk(5, 0, 0), "R6");
      cyc(0, '0, 0, 0, '0, "R10");

      void'($urandom(32'd1234));
      for (int i = 0; i < 400; i++) begin
         int ty, tg, pick;
         pick = int'($urandom_range(0, 5));
         ty = (pick < 2) ? pick : (pick == 2) ? 5 : int'($urandom_range(0, 31));
         case ($urandom_range(0, 3))
            0: tg = 'h10;
            1: tg = 'h21;
            2: tg = 'h3FFF;
            default: tg = int'($urandom_range(0, 'h3FFF));
         endcase
         cyc(bit'($urandom_range(0, 1)), mk(ty, bit'($urandom_range(0, 3) == 0), tg),
             bit'($urandom_range(0, 1)), int'($urandom_range(0, NC-1)),
             mk(int'($urandom_range(0, 5)), bit'($urandom_range(0, 1)), 0), "R11");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD*100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule